// File: doc/BRIEF.md
# Unified Translation Buffer with Entry Load

This block holds the shared table of address translations that a processor core uses for data accesses and as the backing store for a smaller instruction-side buffer. The table is fully associative. Every entry carries its own page size, so 1 KB, 4 KB, 64 KB and 1 MB mappings can live side by side in the same table.

Software prepares a translation in three staging words. The first holds the virtual page and the address-space tag. The second holds the physical page, the valid flag, the size, the protection and the attribute bits. The third holds the space attribute and the timing-control bit. Software then raises the load command. The destination slot is not given by the command itself. It comes from the replacement-counter field of the MMU control word, so the slot choice stays under software control.

A lookup request captures a virtual address and a tag. In the following cycle the block reports one of three results: a single hit with its index and physical address, a miss, or a multiple-hit error. A separate read port shows any entry's stored contents, so a companion instruction buffer can copy that entry.

Top module: `utlb_top`

## Requirements
- R1: While `rst` is high at a clock edge, every entry becomes invalid. After reset, every lookup misses and the read port shows `rd_valid` = 0 for every index.
- R2: When `load_en` is high at a clock edge, the entry whose index is `ctrl_reg[15:10]` is overwritten from the staging words, and the new contents are visible from the next cycle. The other bits of `ctrl_reg` have no effect.
- R3: The address-space tag is taken from `page_hi[7:0]` and the virtual page number from `page_hi[31:10]`.
- R4: From `page_lo`: the physical page number comes from [28:10], valid from bit 8, and protection from [6:5]. `rd_flags` returns `page_lo[3:0]`, in the order cacheable, dirty, shared, write-through from MSB to LSB. `rd_assist` returns `page_assist[3:0]`, with the timing-control bit in bit 3 and the space attribute in bits [2:0].
- R5: The size code is {`page_lo[7]`, `page_lo[4]`}: 00 = 1 KB, 01 = 4 KB, 10 = 64 KB, 11 = 1 MB. The stored code appears on `rd_size`.
- R6: An entry matches an address when the address lies between the page start and the page start plus the size minus 1. The page start is the virtual page number shifted left by 10, with the bits below the page size cleared.
- R7: Entries whose valid bit is 0 never match.
- R8: A lookup is captured when `lkup_req` is high at an edge. In the next cycle exactly one of `hit`, `miss` and `multi_hit` is high. In a cycle that follows an edge without a request, all three are low.
- R9: When two or more entries match, `multi_hit` is raised instead of `hit`. `hit_idx` and `phys_addr` are zero whenever there is no single hit.
- R10: On a hit, `phys_addr` is the entry's physical page number shifted left by 10 with the bits below the page size cleared, ORed with the address bits below the page size. Bits [31:29] are zero.
- R11: When `lkup_use_asid` is 1, an entry matches only if its tag equals `lkup_asid` or its shared bit is set. When `lkup_use_asid` is 0, the tags are ignored.
- R12: The read port returns, in the same cycle, the stored contents of the entry selected by `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_reg | input | 32 | MMU control word; bits [15:10] select the slot to load |
| page_hi | input | 32 | Staging word: virtual page number and address-space tag |
| page_lo | input | 32 | Staging word: physical page number, valid, size, protection, attributes |
| page_assist | input | 32 | Staging word: space attribute and timing-control bit |
| load_en | input | 1 | Load the staging words into the selected slot |
| lkup_req | input | 1 | Capture a lookup |
| lkup_addr | input | 32 | Virtual address to translate |
| lkup_asid | input | 8 | Address-space tag of the lookup |
| lkup_use_asid | input | 1 | Enable the tag comparison |
| hit | output | 1 | Exactly one entry matched |
| miss | output | 1 | No entry matched |
| multi_hit | output | 1 | Two or more entries matched |
| hit_idx | output | 6 | Index of the matching entry |
| phys_addr | output | 32 | Translated address |
| rd_idx | input | 6 | Read-port entry select |
| rd_valid | output | 1 | Stored valid bit |
| rd_asid | output | 8 | Stored tag |
| rd_vpn | output | 22 | Stored virtual page number |
| rd_ppn | output | 19 | Stored physical page number |
| rd_size | output | 2 | Stored size code |
| rd_prot | output | 2 | Stored protection |
| rd_flags | output | 4 | Stored cacheable, dirty, shared, write-through |
| rd_assist | output | 4 | Stored timing-control bit and space attribute |

## Verification
A slot written from the wrong control-word bits, or a staging field stored out of place, is visible on the read port in the very next cycle. Every slot is therefore loaded with distinct contents and read back. A wrong size decode or page-start mask would show one lookup later: an in-page address would miss, or an address one past the page end would still hit. Each slot is therefore probed at its last byte and one byte beyond it. A broken overlap detector would report a single hit with a blended physical address where an error is due. Two deliberately overlapping slots, and then the removal of one of them, exercise this case.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    localparam int VA_W       = 32;
    localparam int ASID_W     = 8;
    localparam int VPN_W      = 22;
    localparam int PPN_W      = 19;
    localparam int PAGE_SHIFT = 10;
    localparam int CTRL_IDX_LSB = 10;
    localparam int FLG_SHARED = 1;

    typedef enum logic [1:0] {
        PG_1K  = 2'b00,
        PG_4K  = 2'b01,
        PG_64K = 2'b10,
        PG_1M  = 2'b11
    } pg_size_e;

    typedef struct packed {
        logic               valid;
        logic [ASID_W-1:0]  asid;
        logic [VPN_W-1:0]   vpn;
        logic [PPN_W-1:0]   ppn;
        pg_size_e           size;
        logic [1:0]         prot;
        logic [3:0]         flags;   // cacheable, dirty, shared, write-through
        logic [3:0]         assist;  // timing control, space attribute[2:0]
    } tlb_entry_t;

    // Offset bits that pass through untranslated for a page size.
    function automatic logic [VA_W-1:0] offset_mask(input pg_size_e sz);
        logic [VA_W-1:0] m;
        unique case (sz)
            PG_1K:   m = 32'h0000_03FF;
            PG_4K:   m = 32'h0000_0FFF;
            PG_64K:  m = 32'h0000_FFFF;
            default: m = 32'h000F_FFFF;
        endcase
        return m;
    endfunction

    // Build an entry from the three staging words.
    function automatic tlb_entry_t pack_entry(input logic [31:0] hi,
                                              input logic [31:0] lo,
                                              input logic [31:0] as);
        tlb_entry_t e;
        e.valid  = lo[8];
        e.asid   = hi[7:0];
        e.vpn    = hi[31:10];
        e.ppn    = lo[28:10];
        e.size   = pg_size_e'({lo[7], lo[4]});
        e.prot   = lo[6:5];
        e.flags  = lo[3:0];
        e.assist = as[3:0];
        return e;
    endfunction

endpackage

// File: rtl/utlb_store.sv
module utlb_store
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  tlb_entry_t                wr_entry,
    output tlb_entry_t [ENTRIES-1:0]  table_o
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlb_entry_t slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q <= wr_entry;
            end
        end
        assign table_o[g] = slot_q;
    end

endmodule

// File: rtl/utlb_match.sv
module utlb_match
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  tlb_entry_t [ENTRIES-1:0] table_i,
    input  logic [VA_W-1:0]          addr,
    input  logic [ASID_W-1:0]        asid,
    input  logic                     use_asid,
    output logic [ENTRIES-1:0]       match_o
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VA_W-1:0] mask;
        logic [VA_W-1:0] base;
        logic            tag_ok;
        logic            unused_fields;

        assign mask   = offset_mask(table_i[g].size);
        assign base   = {table_i[g].vpn, {PAGE_SHIFT{1'b0}}} & ~mask;
        assign tag_ok = !use_asid || (table_i[g].asid == asid)
                        || table_i[g].flags[FLG_SHARED];
        assign match_o[g] = table_i[g].valid && tag_ok
                            && ((addr & ~mask) == base);
        assign unused_fields = ^{table_i[g].ppn, table_i[g].prot,
                                 table_i[g].assist, table_i[g].flags};
    end

endmodule

// File: rtl/utlb_resolve.sv
module utlb_resolve #(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] match_i,
    output logic               any_o,
    output logic               multi_o,
    output logic [IDX_W-1:0]   idx_o
);

    // OR-encode the index: correct whenever exactly one lane is set.
    always_comb begin
        any_o   = 1'b0;
        multi_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_i[i]) begin
                multi_o = multi_o | any_o;
                any_o   = 1'b1;
                idx_o   = idx_o | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/utlb_top.sv
module utlb_top
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       ctrl_reg,
    input  logic [31:0]       page_hi,
    input  logic [31:0]       page_lo,
    input  logic [31:0]       page_assist,
    input  logic              load_en,
    input  logic              lkup_req,
    input  logic [31:0]       lkup_addr,
    input  logic [7:0]        lkup_asid,
    input  logic              lkup_use_asid,
    output logic              hit,
    output logic              miss,
    output logic              multi_hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [31:0]       phys_addr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [7:0]        rd_asid,
    output logic [21:0]       rd_vpn,
    output logic [18:0]       rd_ppn,
    output logic [1:0]        rd_size,
    output logic [1:0]        rd_prot,
    output logic [3:0]        rd_flags,
    output logic [3:0]        rd_assist
);

    tlb_entry_t [ENTRIES-1:0] table_w;
    tlb_entry_t               new_entry;
    tlb_entry_t               hit_entry;
    tlb_entry_t               rd_entry;
    logic [ENTRIES-1:0]       match_w;
    logic                     any_w;
    logic                     multi_w;
    logic [IDX_W-1:0]         idx_w;
    logic [VA_W-1:0]          hit_mask;
    logic [VA_W-1:0]          xlat_addr;

    logic                     req_q;
    logic [VA_W-1:0]          addr_q;
    logic [ASID_W-1:0]        asid_q;
    logic                     use_asid_q;
    logic                     unused_inputs;

    assign new_entry = pack_entry(page_hi, page_lo, page_assist);

    utlb_store #(.ENTRIES(ENTRIES)) store_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (load_en),
        .wr_idx   (ctrl_reg[CTRL_IDX_LSB +: IDX_W]),
        .wr_entry (new_entry),
        .table_o  (table_w)
    );

    // Lookup operands are registered; matching runs from the registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= 1'b0;
            addr_q     <= '0;
            asid_q     <= '0;
            use_asid_q <= 1'b0;
        end else begin
            req_q <= lkup_req;
            if (lkup_req) begin
                addr_q     <= lkup_addr;
                asid_q     <= lkup_asid;
                use_asid_q <= lkup_use_asid;
            end
        end
    end

    utlb_match #(.ENTRIES(ENTRIES)) match_i (
        .table_i  (table_w),
        .addr     (addr_q),
        .asid     (asid_q),
        .use_asid (use_asid_q),
        .match_o  (match_w)
    );

    utlb_resolve #(.ENTRIES(ENTRIES)) resolve_i (
        .match_i (match_w),
        .any_o   (any_w),
        .multi_o (multi_w),
        .idx_o   (idx_w)
    );

    assign hit_entry = table_w[idx_w];
    assign hit_mask  = offset_mask(hit_entry.size);
    assign xlat_addr = ({{(VA_W-PPN_W-PAGE_SHIFT){1'b0}}, hit_entry.ppn,
                         {PAGE_SHIFT{1'b0}}} & ~hit_mask)
                       | (addr_q & hit_mask);

    assign hit       = req_q && any_w && !multi_w;
    assign miss      = req_q && !any_w;
    assign multi_hit = req_q && multi_w;
    assign hit_idx   = hit ? idx_w : '0;
    assign phys_addr = hit ? xlat_addr : '0;

    assign rd_entry  = table_w[rd_idx];
    assign rd_valid  = rd_entry.valid;
    assign rd_asid   = rd_entry.asid;
    assign rd_vpn    = rd_entry.vpn;
    assign rd_ppn    = rd_entry.ppn;
    assign rd_size   = rd_entry.size;
    assign rd_prot   = rd_entry.prot;
    assign rd_flags  = rd_entry.flags;
    assign rd_assist = rd_entry.assist;

    assign unused_inputs = ^{ctrl_reg, page_hi[9:8], page_lo[31:29],
                             page_lo[9], page_assist[31:4]};

endmodule

// File: rtl/utlb_checker.sv
module utlb_checker #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [31:0]      ctrl_reg,
    input logic [31:0]      page_hi,
    input logic [31:0]      page_lo,
    input logic             load_en,
    input logic             lkup_req,
    input logic [31:0]      lkup_addr,
    input logic             hit,
    input logic             miss,
    input logic             multi_hit,
    input logic [IDX_W-1:0] hit_idx,
    input logic [31:0]      phys_addr,
    input logic [IDX_W-1:0] rd_idx,
    input logic             rd_valid,
    input logic [21:0]      rd_vpn
);

    logic unused_chk;
    assign unused_chk = ^{ctrl_reg, page_hi, page_lo, lkup_addr};

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        lkup_req |=> ($countones({hit, miss, multi_hit}) == 1)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lkup_req |=> !(hit || miss || multi_hit)); // R8

    AST_NOHIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_idx == '0 && phys_addr == '0)); // R9

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        lkup_req |=> (hit -> phys_addr[9:0] == $past(lkup_addr[9:0]))); // R10

    AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (load_en && rd_idx == ctrl_reg[10 +: IDX_W]) |=>
        ($stable(rd_idx) -> (rd_valid == $past(page_lo[8])
                             && rd_vpn == $past(page_hi[31:10])))); // R2

endmodule

bind utlb_top utlb_checker #(.IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl_reg  (ctrl_reg),
    .page_hi   (page_hi),
    .page_lo   (page_lo),
    .load_en   (load_en),
    .lkup_req  (lkup_req),
    .lkup_addr (lkup_addr),
    .hit       (hit),
    .miss      (miss),
    .multi_hit (multi_hit),
    .hit_idx   (hit_idx),
    .phys_addr (phys_addr),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_vpn    (rd_vpn)
);

// File: tb/utlb_top_tb.sv
`timescale 1ns/1ps
module utlb_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctrl_reg = '0;
    logic [31:0] page_hi = '0;
    logic [31:0] page_lo = '0;
    logic [31:0] page_assist = '0;
    logic        load_en = 1'b0;
    logic        lkup_req = 1'b0;
    logic [31:0] lkup_addr = '0;
    logic [7:0]  lkup_asid = '0;
    logic        lkup_use_asid = 1'b0;
    logic        hit, miss, multi_hit;
    logic [5:0]  hit_idx;
    logic [31:0] phys_addr;
    logic [5:0]  rd_idx = '0;
    logic        rd_valid;
    logic [7:0]  rd_asid;
    logic [21:0] rd_vpn;
    logic [18:0] rd_ppn;
    logic [1:0]  rd_size, rd_prot;
    logic [3:0]  rd_flags, rd_assist;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic        o_hit, o_miss, o_multi;
    logic [5:0]  o_idx;
    logic [31:0] o_pa;

    utlb_top dut_i (
        .clk(clk), .rst(rst), .ctrl_reg(ctrl_reg), .page_hi(page_hi),
        .page_lo(page_lo), .page_assist(page_assist), .load_en(load_en),
        .lkup_req(lkup_req), .lkup_addr(lkup_addr), .lkup_asid(lkup_asid),
        .lkup_use_asid(lkup_use_asid), .hit(hit), .miss(miss),
        .multi_hit(multi_hit), .hit_idx(hit_idx), .phys_addr(phys_addr),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_asid(rd_asid),
        .rd_vpn(rd_vpn), .rd_ppn(rd_ppn), .rd_size(rd_size),
        .rd_prot(rd_prot), .rd_flags(rd_flags), .rd_assist(rd_assist)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] size_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 32'd1024;
            2'b01:   return 32'd4096;
            2'b10:   return 32'd65536;
            default: return 32'd1048576;
        endcase
    endfunction

    function automatic logic [21:0] vpn_of(input int i);
        return 22'((i << 10) | 15);
    endfunction
    function automatic logic [18:0] ppn_of(input int i);
        return 19'(((i + 1) << 10) | (i & 63));
    endfunction
    function automatic logic [3:0] flags_of(input int i);
        return {i[2], i[3], i[0], i[4]};
    endfunction
    function automatic logic [1:0] prot_of(input int i);
        return 2'((i >> 1) & 3);
    endfunction
    function automatic logic [3:0] assist_of(input int i);
        return 4'((i * 5) & 15);
    endfunction
    function automatic logic [31:0] start_of(input logic [21:0] vpn,
                                             input logic [1:0] sz);
        return ({vpn, 10'b0}) & ~(size_bytes(sz) - 32'd1);
    endfunction
    function automatic logic [31:0] pa_of(input logic [18:0] ppn,
                                          input logic [1:0] sz,
                                          input logic [31:0] a);
        logic [31:0] m;
        m = size_bytes(sz) - 32'd1;
        return ({3'b0, ppn, 10'b0} & ~m) | (a & m);
    endfunction
    function automatic logic [31:0] lo_word(input logic [18:0] ppn, input logic v,
                                            input logic [1:0] sz, input logic [1:0] pr,
                                            input logic [3:0] fl);
        return {3'b111, ppn, 1'b1, v, sz[1], pr, sz[0], fl};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [21:0] vpn, input logic [7:0] asid,
                        input logic [31:0] lo, input logic [3:0] asst);
        @(negedge clk);
        ctrl_reg    = 32'hFFFF_03FF | (32'(idx) << 10);
        page_hi     = {vpn, 2'b11, asid};
        page_lo     = lo;
        page_assist = {28'hABCDEF0, asst};
        load_en     = 1'b1;
        @(negedge clk);
        load_en     = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input logic [7:0] asid, input logic use_t);
        @(negedge clk);
        lkup_addr = a; lkup_asid = asid; lkup_use_asid = use_t; lkup_req = 1'b1;
        @(negedge clk);
        o_hit = hit; o_miss = miss; o_multi = multi_hit; o_idx = hit_idx; o_pa = phys_addr;
        lkup_req = 1'b0;
    endtask

    task automatic expect_hit(input int idx, input logic [31:0] pa, input string req);
        chk(o_hit && !o_miss && !o_multi, req, {o_hit, o_miss, o_multi}, 3'b100);
        chk(o_idx == 6'(idx), req, o_idx, idx);
        chk(o_pa == pa, req, o_pa, pa);
    endtask

    task automatic expect_miss(input string req);
        chk(!o_hit && o_miss && !o_multi, req, {o_hit, o_miss, o_multi}, 3'b010);
        chk(o_pa == 0 && o_idx == 0, req, o_pa, 0);
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        for (int i = 0; i < 64; i++) begin
            rd_idx = 6'(i); #0.5;
            chk(rd_valid == 1'b0, "R1 reset valid", rd_valid, 0);
        end
        lookup(32'h0000_0000, 8'h0, 1'b0);
        expect_miss("R1 reset lookup");

        // R8: no request -> all result flags low
        @(negedge clk);
        chk(!(hit || miss || multi_hit), "R8 idle quiet", {hit, miss, multi_hit}, 0);

        // R2 R3 R4 R5: fill all slots and read back
        for (int i = 0; i < 64; i++)
            load(i, vpn_of(i), 8'(i),
                 lo_word(ppn_of(i), 1'b1, 2'(i % 4), prot_of(i), flags_of(i)),
                 assist_of(i));
        for (int i = 0; i < 64; i++) begin
            rd_idx = 6'(i); #0.5;
            chk(rd_valid == 1'b1, "R4 valid", rd_valid, 1);
            chk(rd_asid == 8'(i), "R3 asid", rd_asid, i);
            chk(rd_vpn == vpn_of(i), "R3 vpn", rd_vpn, vpn_of(i));
            chk(rd_ppn == ppn_of(i), "R4 ppn", rd_ppn, ppn_of(i));
            chk(rd_size == 2'(i % 4), "R5 size", rd_size, i % 4);
            chk(rd_prot == prot_of(i), "R4 prot", rd_prot, prot_of(i));
            chk(rd_flags == flags_of(i), "R4 flags", rd_flags, flags_of(i));
            chk(rd_assist == assist_of(i), "R12 assist", rd_assist, assist_of(i));
        end

        // R6 R10: last byte of each page hits, one byte past misses
        for (int i = 0; i < 64; i++) begin
            logic [31:0] s, last;
            s = start_of(vpn_of(i), 2'(i % 4));
            last = s + size_bytes(2'(i % 4)) - 1;
            lookup(last, 8'h0, 1'b0);
            expect_hit(i, pa_of(ppn_of(i), 2'(i % 4), last), "R6 R10 page end");
            lookup(s, 8'h0, 1'b0);
            expect_hit(i, pa_of(ppn_of(i), 2'(i % 4), s), "R6 page start");
            if (i % 4 != 3) begin
                lookup(last + 1, 8'h0, 1'b0);
                expect_miss("R6 past end");
            end
        end

        // R11: tag compare
        lookup(start_of(vpn_of(2), 2'd2), 8'd2, 1'b1);
        expect_hit(2, pa_of(ppn_of(2), 2'd2, start_of(vpn_of(2), 2'd2)), "R11 tag equal");
        lookup(start_of(vpn_of(2), 2'd2), 8'd3, 1'b1);
        expect_miss("R11 tag differs");
        lookup(start_of(vpn_of(3), 2'd3), 8'd7, 1'b1);
        expect_hit(3, pa_of(ppn_of(3), 2'd3, start_of(vpn_of(3), 2'd3)), "R11 shared");

        // R9: overlap slot 63 (1 MB) on slot 9's region
        load(63, 22'(9 << 10), 8'd63, lo_word(19'h7FFFF, 1'b1, 2'b11, 2'b00, 4'h0), 4'h0);
        lookup(start_of(vpn_of(9), 2'd1), 8'h0, 1'b0);
        chk(o_multi && !o_hit && !o_miss, "R9 multi", {o_hit, o_miss, o_multi}, 3'b001);
        chk(o_idx == 0 && o_pa == 0, "R9 multi zero", o_pa, 0);
        lookup(32'h0098_0000, 8'h0, 1'b0);
        expect_hit(63, pa_of(19'h7FFFF, 2'b11, 32'h0098_0000), "R9 R10 single overlap");
        lookup(32'h03F0_0000, 8'h0, 1'b0);
        expect_miss("R2 overwritten slot");

        // R7: invalidate slot 63, overlap disappears
        load(63, 22'(9 << 10), 8'd63, lo_word(19'h7FFFF, 1'b0, 2'b11, 2'b00, 4'h0), 4'h0);
        rd_idx = 6'd63; #0.5;
        chk(rd_valid == 1'b0, "R7 read invalid", rd_valid, 0);
        lookup(start_of(vpn_of(9), 2'd1), 8'h0, 1'b0);
        expect_hit(9, pa_of(ppn_of(9), 2'd1, start_of(vpn_of(9), 2'd1)), "R7 invalid ignored");
        lookup(32'h0098_0000, 8'h0, 1'b0);
        expect_miss("R7 invalid no match");

        // R1: reset clears a filled table
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        lookup(start_of(vpn_of(5), 2'd1), 8'h0, 1'b0);
        expect_miss("R1 reset after fill");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule